// File: doc/BRIEF.md
# Serial-Chain Priority Interrupt Arbiter

The block joins a row of interrupt-raising device stages to a processor-side interrupt controller through a serial priority chain. A device raises its request with a rising edge on its own input. Each stage passes that edge through a two-flop synchroniser and keeps a pending flag. The stages share an active-low request line that is pulled low while any flag is set.

When its interrupt-enable flag is set and the line is low, the controller asserts an acknowledge for one clock and clears the enable flag. The acknowledge enters the first stage, which holds the highest priority. It ripples combinationally from stage to stage, and the first stage with a pending flag stops it there. That stage wins: it places its fixed vector on the shared vector bus and drops its pending flag. The controller registers the vector and raises a one-cycle valid strobe. A return pulse from software sets the enable flag again, which lets the next acknowledge take place.

Priority comes only from a stage's position in the chain. Arrival time has no effect on it.

Top module: `irq_daisy_arbiter`

## Requirements
- R1: After reset, `irq_n_o` is 1, `ack_o` is 0, `grant_o` is all zero, `vec_vld_o` is 0, and the enable flag is set.
- R2: When `req_i[k]` rises, `irq_n_o` goes to 0 on the third rising clock edge after the change, counting two synchroniser stages and the pending flag. `irq_n_o` is 1 whenever no stage has a pending flag.
- R3: When the enable flag is set and `irq_n_o` is 0, `ack_o` goes to 1 on the next edge and stays high for exactly one cycle. The same edge clears the enable flag.
- R4: While the enable flag is clear, no acknowledge is issued, even with `irq_n_o` low. A one-cycle pulse on `iret_i` sets the flag again.
- R5: While `ack_o` is 1, `grant_o[k]` is 1 only for the lowest index k with a pending flag. Index 0 is the highest priority. At most one grant bit is ever set.
- R6: On the edge after an acknowledge, `vec_o` takes the winner's vector, `VEC_BASE + k*VEC_STEP`, and `vec_vld_o` is 1 for that one cycle. With the defaults, stages 0 to 3 give 0x40, 0x44, 0x48 and 0x4C.
- R7: The winning stage clears its pending flag on the acknowledge edge. Stages that lost keep their flags and are served in chain order after later returns.
- R8: A request that stays high after it has been served does not raise `irq_n_o` again. Only a new rising edge on `req_i[k]` sets the pending flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Device requests, asynchronous, rising edge sets pending |
| iret_i | input | 1 | Return pulse, sets the enable flag again |
| irq_n_o | output | 1 | Shared request line, active low |
| ack_o | output | 1 | One-cycle acknowledge that feeds the chain head |
| grant_o | output | N_DEV | Per-stage grant, one-hot or zero |
| vec_o | output | VEC_W | Registered vector of the last winner |
| vec_vld_o | output | 1 | One-cycle strobe that marks a new vector |

## Verification
Two functions can act in the same cycle. Several stages can be pending when an acknowledge arrives, so the chain has to decide between them. A stage's pending flag can also be set while the enable flag is clear. The bench provokes the first case by raising three requests in one cycle. It provokes the second by raising a low-priority request and then a higher-priority one while the controller waits for its return pulse. A scoreboard checks that the vectors come out in chain order, not in arrival order, and that no acknowledge appears before the return pulse.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic logic [31:0] stage_vector(input logic [31:0] base,
                                               input logic [31:0] step,
                                               input int unsigned idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import irq_chain_pkg::*;

  logic [SYNC_STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[SYNC_STAGES-2:0], d_i};
  end

  assign q_o = ff_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_chain_stage.sv
module irq_chain_stage #(
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             pi_i,
  output logic             po_o,
  output logic             grant_o,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  logic req_s, req_prev_q, pend_q, set_edge;

  irq_sync2 u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_i),
    .q_o    (req_s)
  );

  assign set_edge = req_s & ~req_prev_q;
  assign grant_o  = pi_i & pend_q;
  assign po_o     = pi_i & ~pend_q;
  assign pend_o   = pend_q;
  assign vec_o    = grant_o ? VEC : '0;

  // new edge wins over clear so a fresh request is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_prev_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      req_prev_q <= req_s;
      pend_q     <= set_edge | (pend_q & ~grant_o);
    end
  end
endmodule

// File: rtl/irq_cpu_ctrl.sv
module irq_cpu_ctrl #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_n_i,
  input  logic             iret_i,
  input  logic [VEC_W-1:0] vec_bus_i,
  output logic             ack_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  logic ie_q, ack_q, ack_d;

  assign ack_d = ie_q & ~irq_n_i & ~ack_q;
  assign ack_o = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q      <= 1'b1;
      ack_q     <= 1'b0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
    end else begin
      ack_q     <= ack_d;
      vec_vld_o <= ack_q;
      if (ack_q) vec_o <= vec_bus_i;
      if (ack_d)       ie_q <= 1'b0;
      else if (iret_i) ie_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_daisy_arbiter.sv
module irq_daisy_arbiter #(
  parameter int unsigned N_DEV    = 4,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 32'h40,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic             iret_i,
  output logic             irq_n_o,
  output logic             ack_o,
  output logic [N_DEV-1:0] grant_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  import irq_chain_pkg::*;

  logic [N_DEV:0]   pi;
  logic [N_DEV-1:0] pend;
  logic [VEC_W-1:0] vec_part [N_DEV];
  logic [VEC_W-1:0] vec_or   [N_DEV+1];

  assign pi[0]     = ack_o;
  assign vec_or[0] = '0;

  for (genvar k = 0; k < N_DEV; k++) begin : g_stage
    localparam logic [31:0] VEC_FULL = stage_vector(VEC_BASE, VEC_STEP, k);
    irq_chain_stage #(
      .VEC_W (VEC_W),
      .VEC   (VEC_FULL[VEC_W-1:0])
    ) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i[k]),
      .pi_i    (pi[k]),
      .po_o    (pi[k+1]),
      .grant_o (grant_o[k]),
      .pend_o  (pend[k]),
      .vec_o   (vec_part[k])
    );
    assign vec_or[k+1] = vec_or[k] | vec_part[k];
  end

  // wired-OR request line, active low
  assign irq_n_o = ~|pend;

  irq_cpu_ctrl #(.VEC_W(VEC_W)) u_cpu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_n_i   (irq_n_o),
    .iret_i    (iret_i),
    .vec_bus_i (vec_or[N_DEV]),
    .ack_o     (ack_o),
    .vec_o     (vec_o),
    .vec_vld_o (vec_vld_o)
  );
endmodule

// File: rtl/irq_daisy_arbiter_chk.sv
module irq_daisy_arbiter_chk #(
  parameter int unsigned N_DEV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iret_i,
  input logic             irq_n_o,
  input logic             ack_o,
  input logic [N_DEV-1:0] grant_o,
  input logic             vec_vld_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b1;
    else if (ack_o)  armed_q <= 1'b0;
    else if (iret_i) armed_q <= 1'b1;
  end

  AST_ACK_ONE_CYCLE:  assert property (@(posedge clk_i) disable iff (!rst_ni) ack_o |=> !ack_o); // R3
  AST_ACK_NEEDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni) ack_o |-> !irq_n_o); // R3
  AST_ACK_NEEDS_RET:  assert property (@(posedge clk_i) disable iff (!rst_ni) ack_o |-> armed_q); // R4
  AST_GRANT_ONEHOT:   assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant_o)); // R5
  AST_GRANT_ON_ACK:   assert property (@(posedge clk_i) disable iff (!rst_ni) ack_o |-> $countones(grant_o) == 1); // R5
  AST_VLD_AFTER_ACK:  assert property (@(posedge clk_i) disable iff (!rst_ni) ack_o |=> vec_vld_o); // R6
  AST_VLD_ONE_CYCLE:  assert property (@(posedge clk_i) disable iff (!rst_ni) vec_vld_o |=> !vec_vld_o); // R6
endmodule

bind irq_daisy_arbiter irq_daisy_arbiter_chk #(.N_DEV(N_DEV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .iret_i    (iret_i),
  .irq_n_o   (irq_n_o),
  .ack_o     (ack_o),
  .grant_o   (grant_o),
  .vec_vld_o (vec_vld_o)
);

// File: tb/tb_irq_daisy_arbiter.sv
module tb_irq_daisy_arbiter;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         iret = 1'b0;
  logic         irq_n, ack, vld;
  logic [N-1:0] grant;
  logic [W-1:0] vec;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] exp_q [$];
  bit done = 0;

  always #2ns clk = ~clk;

  irq_daisy_arbiter #(.N_DEV(N), .VEC_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .iret_i(iret),
    .irq_n_o(irq_n), .ack_o(ack), .grant_o(grant), .vec_o(vec), .vec_vld_o(vld)
  );

  function automatic logic [W-1:0] vec_of(int k);
    return W'(8'h40 + 4 * k);
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_vld();
    do tick(); while (!vld);
  endtask

  task automatic pulse_ret();
    iret = 1'b1; tick(); iret = 1'b0;
  endtask

  // monitor: compares each strobed vector against the scoreboard
  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (exp_q.size() == 0) check("R6 unexpected vector", {24'h0, vec}, 32'hFFFF);
      else check("R6 R5 vector order", {24'h0, vec}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    // R1
    check("R1 irq_n", irq_n, 1);
    check("R1 ack", ack, 0);
    check("R1 grant", grant, 0);
    check("R1 vld", vld, 0);

    // single request on stage 2: latency and grant
    exp_q.push_back(vec_of(2));
    req[2] = 1'b1;
    tick(2);
    check("R2 irq_n before 3rd edge", irq_n, 1);
    tick();
    check("R2 irq_n after 3rd edge", irq_n, 0);
    tick();
    check("R3 ack asserted", ack, 1);
    check("R5 single grant", grant, 4'b0100);
    tick();
    check("R3 ack one cycle", ack, 0);
    check("R7 pending cleared", irq_n, 1);
    check("R6 vld strobe", vld, 1);
    req[2] = 1'b0;
    pulse_ret();

    // three simultaneous requests, served in chain order
    exp_q.push_back(vec_of(0));
    exp_q.push_back(vec_of(1));
    exp_q.push_back(vec_of(3));
    req = 4'b1011;
    wait_vld();
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R4 no ack while disabled", ack, 0);
    end
    check("R7 losers still pending", irq_n, 0);
    pulse_ret();
    wait_vld();
    pulse_ret();
    wait_vld();
    pulse_ret();
    // req[1] stays high: no new request
    for (int i = 0; i < 10; i++) begin
      tick();
      check("R8 held request not re-raised", irq_n, 1);
    end
    req = '0;
    tick(4);

    // low priority arrives first, high priority later, while disabled
    exp_q.push_back(vec_of(2));
    exp_q.push_back(vec_of(0));
    exp_q.push_back(vec_of(3));
    req[2] = 1'b1;
    wait_vld();
    req[3] = 1'b1;
    tick(5);
    req[0] = 1'b1;
    tick(5);
    check("R4 still no ack", ack, 0);
    pulse_ret();
    wait_vld();
    pulse_ret();
    wait_vld();
    pulse_ret();
    tick(4);
    check("R2 line high when idle", irq_n, 1);
    check("R6 scoreboard drained", exp_q.size(), 0);
    req = '0;
    tick(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule